// File: doc/BRIEF.md
# Processor Start-up Message Sequencer

This block wakes a sleeping processor core by issuing three inter-processor messages through the interrupt command register: an INIT message, then a start-up message, then a second identical start-up message. A single start pulse, a target identifier (or a broadcast flag for every core except the sender) and a start-up routine address are all it needs. The block then writes the destination word and the command word for each message in turn. Before going on, it waits until the fabric reports that the message was accepted. It also inserts fixed wait times measured on a microsecond time base derived from the clock.

The routine address is checked when the request is taken. It must lie below 1 MiB and sit on a 4 KiB boundary. The start-up vector is the address divided by 4096. A bad address is refused with a one-cycle error pulse, and no message goes out. A start request that arrives while a sequence is running is dropped.

Top module: `ipi_startup_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o and cmd_wr_o are all low.
- R2: In idle, a start request whose address has any bit set at or above bit 20, or any bit set in bits 11:0, raises error_o for exactly one cycle, in the cycle after the request. It issues no command write and leaves busy_o low.
- R3: Each message is two writes on consecutive cycles. First comes the destination word (cmd_sel_o=0), holding the 8-bit target in bits 31:24 and zeros elsewhere. Then comes the command word (cmd_sel_o=1). Writing the command word is what sends the message.
- R4: The command word carries the delivery mode in bits 10:8 (INIT = 3'b101, start-up = 3'b110) and a 1 in bit 14. Bits 19:18 hold 2'b11 for broadcast and 2'b00 otherwise. For start-up messages, bits 7:0 hold address bits 19:12. Every other bit is 0.
- R5: An accepted request issues exactly three messages in the order INIT, start-up, start-up, and the two start-up command words are identical.
- R6: After each command word the block makes no further write while cmd_pend_i is high. It moves on only once it has seen cmd_pend_i low in a cycle after that write.
- R7: With D = SHORT_US*CLKS_PER_US, the next destination write follows the INIT acceptance cycle by exactly D+1 cycles. With L = LONG_US*CLKS_PER_US, the next destination write follows the first start-up acceptance cycle by exactly L+1 cycles.
- R8: done_o pulses for one cycle, in the cycle after the final start-up message is accepted, and busy_o is low in that cycle.
- R9: With bcast_i set, the destination word is all zeros, whatever target_i holds.
- R10: A start request while busy_o is high has no effect: no error pulse, and no change to the running sequence's writes.
- R11: cmd_wr_o is only ever high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle start request |
| bcast_i | input | 1 | Send to all cores except the sender |
| target_i | input | 8 | Target core identifier |
| routine_i | input | ADDR_W | Start-up routine address |
| cmd_pend_i | input | 1 | Delivery pending: high from the cycle after a command write until accepted |
| cmd_wr_o | output | 1 | Command register write strobe |
| cmd_sel_o | output | 1 | 0 selects the destination word, 1 the command word |
| cmd_data_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle address rejection pulse |

## Verification
The sharpest collision is a new start request that lands while a sequence is still waiting for acceptance or counting a delay. Here the request path and the running sequence compete for the same capture registers. The bench provokes this by pulsing start with a bad address and a different target just after the first command write. It then judges the outcome at the ports: no error pulse may appear, and all six writes must still carry the first target, the first vector and the exact gaps.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEST = 3'd1,
    ST_CMD  = 3'd2,
    ST_ACK  = 3'd3,
    ST_GAP  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    MSG_INIT = 2'd0,
    MSG_SU1  = 2'd1,
    MSG_SU2  = 2'd2
  } seq_step_e;

  localparam int          TGT_W     = 8;
  localparam logic [2:0]  MODE_INIT = 3'b101;
  localparam logic [2:0]  MODE_SU   = 3'b110;
  localparam logic [1:0]  SH_ALLX   = 2'b11;
  localparam int          ADDR_TOP  = 20;
  localparam int          PAGE_BITS = 12;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/ipi_addr_check.sv
module ipi_addr_check
  import ipi_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic [7:0]        vec_o
);
  localparam int HI_W = ADDR_W - ADDR_TOP;

  logic below_limit;
  logic aligned;

  generate
    if (HI_W > 0) begin : g_hi
      assign below_limit = (addr_i[ADDR_W-1:ADDR_TOP] == '0);
    end else begin : g_nohi
      assign below_limit = 1'b1;
    end
  endgenerate

  assign aligned = (addr_i[PAGE_BITS-1:0] == '0);
  assign ok_o    = below_limit & aligned;
  assign vec_o   = addr_i[ADDR_TOP-1:PAGE_BITS];
endmodule

// File: rtl/ipi_delay_timer.sv
module ipi_delay_timer #(
  parameter int CLKS_PER_US = 250,
  parameter int SHORT_US    = 10,
  parameter int LONG_US     = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic long_i,
  output logic zero_o
);
  localparam int SHORT_CYC = CLKS_PER_US * SHORT_US;
  localparam int LONG_CYC  = CLKS_PER_US * LONG_US;
  localparam int CNT_W     = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = long_i ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ipi_startup_seq.sv
module ipi_startup_seq
  import ipi_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CLKS_PER_US = 250,
  parameter int SHORT_US    = 10,
  parameter int LONG_US     = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bcast_i,
  input  logic [7:0]        target_i,
  input  logic [ADDR_W-1:0] routine_i,
  input  logic              cmd_pend_i,
  output logic              cmd_wr_o,
  output logic              cmd_sel_o,
  output logic [31:0]       cmd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  logic       rst_q_n;
  logic       addr_ok;
  logic [7:0] addr_vec;
  logic       tmr_load, tmr_long, tmr_zero;

  seq_state_e state_q, state_d;
  seq_step_e  step_q, step_d;
  logic       capture;
  logic       bcast_q;
  logic [7:0] tgt_q, vec_q;
  logic       done_d, err_d;
  logic [31:0] dest_word, cmd_word;
  logic [2:0]  mode;

  ipi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  ipi_addr_check #(.ADDR_W(ADDR_W)) u_chk (
    .addr_i(routine_i), .ok_o(addr_ok), .vec_o(addr_vec)
  );

  ipi_delay_timer #(
    .CLKS_PER_US(CLKS_PER_US), .SHORT_US(SHORT_US), .LONG_US(LONG_US)
  ) u_tmr (
    .clk(clk), .rst_n(rst_q_n), .load_i(tmr_load), .long_i(tmr_long), .zero_o(tmr_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    capture  = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_long = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (addr_ok) begin
            capture = 1'b1;
            step_d  = MSG_INIT;
            state_d = ST_DEST;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_DEST: state_d = ST_CMD;
      ST_CMD:  state_d = ST_ACK;
      ST_ACK: begin
        if (!cmd_pend_i) begin
          if (step_q == MSG_SU2) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            tmr_load = 1'b1;
            tmr_long = (step_q == MSG_SU1);
            step_d   = (step_q == MSG_INIT) ? MSG_SU1 : MSG_SU2;
            state_d  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) state_d = ST_DEST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      step_q  <= MSG_INIT;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_o  <= done_d;
      error_o <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bcast_q <= 1'b0;
      tgt_q   <= '0;
      vec_q   <= '0;
    end else if (capture) begin
      bcast_q <= bcast_i;
      tgt_q   <= target_i;
      vec_q   <= addr_vec;
    end
  end

  // message encoding
  always_comb begin
    mode     = (step_q == MSG_INIT) ? MODE_INIT : MODE_SU;
    cmd_word = '0;
    cmd_word[10:8] = mode;
    cmd_word[14]   = 1'b1;
    cmd_word[19:18] = bcast_q ? SH_ALLX : 2'b00;
    cmd_word[7:0]  = (step_q == MSG_INIT) ? 8'h00 : vec_q;
    dest_word = bcast_q ? 32'h0 : {tgt_q, 24'h0};
  end

  assign cmd_wr_o   = (state_q == ST_DEST) || (state_q == ST_CMD);
  assign cmd_sel_o  = (state_q == ST_CMD);
  assign cmd_data_o = cmd_sel_o ? cmd_word : dest_word;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

module ipi_startup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        cmd_wr_o,
  input logic        cmd_sel_o,
  input logic [31:0] cmd_data_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        error_o
);
  a_r2_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);
  a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !busy_o);
  a_r3_cmd_after_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_o && !cmd_sel_o) |=> (cmd_wr_o && cmd_sel_o));
  a_r4_level_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_o && cmd_sel_o) |-> cmd_data_o[14]);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r10_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !error_o);
  a_r11_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_o |-> busy_o);
endmodule

bind ipi_startup_seq ipi_startup_seq_chk u_chk_bind (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_wr_o(cmd_wr_o),
  .cmd_sel_o(cmd_sel_o), .cmd_data_o(cmd_data_o), .busy_o(busy_o),
  .done_o(done_o), .error_o(error_o)
);

// File: tb/ipi_startup_seq_tb_top.sv
module ipi_startup_seq_tb_top;
  localparam int CPU = 10;
  localparam int SHORT_CYC = CPU * 10;
  localparam int LONG_CYC  = CPU * 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bcast = 1'b0;
  logic [7:0] target = 8'h0;
  logic [31:0] routine = 32'h0;
  logic pend = 1'b0;
  logic cmd_wr, cmd_sel, busy, done, error;
  logic [31:0] cmd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_wr = 0;
  int wr_cyc [16];
  logic wr_sel [16];
  logic [31:0] wr_dat [16];
  int done_cyc = -1;
  int done_cnt = 0;
  int err_cnt = 0;
  int busy_cnt = 0;
  logic busy_at_done = 1'b0;
  int ack_lat = 1;
  int pend_cnt = 0;

  always #2 clk = ~clk;

  ipi_startup_seq #(.CLKS_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bcast_i(bcast), .target_i(target),
    .routine_i(routine), .cmd_pend_i(pend), .cmd_wr_o(cmd_wr), .cmd_sel_o(cmd_sel),
    .cmd_data_o(cmd_data), .busy_o(busy), .done_o(done), .error_o(error)
  );

  // monitor and acceptance model, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cmd_wr && n_wr < 16) begin
      wr_cyc[n_wr] = cyc; wr_sel[n_wr] = cmd_sel; wr_dat[n_wr] = cmd_data;
      n_wr = n_wr + 1;
    end
    if (done) begin done_cyc = cyc; done_cnt = done_cnt + 1; busy_at_done = busy; end
    if (error) err_cnt = err_cnt + 1;
    if (busy) busy_cnt = busy_cnt + 1;
    if (pend_cnt > 0) pend_cnt = pend_cnt - 1;
    if (cmd_wr && cmd_sel) pend_cnt = ack_lat;
    pend = (pend_cnt != 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    n_wr = 0; done_cyc = -1; done_cnt = 0; err_cnt = 0; busy_cnt = 0;
  endtask

  task automatic pulse_start(input bit b, input logic [7:0] t, input logic [31:0] a);
    @(negedge clk);
    start = 1'b1; bcast = b; target = t; routine = a;
    @(negedge clk);
    start = 1'b0; target = 8'h00; routine = 32'hFFFF_FFFF; bcast = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_seq(input bit b, input logic [7:0] t, input logic [31:0] a, input int lat);
    logic [31:0] dexp, lo_init, lo_su;
    dexp = b ? 32'h0 : {t, 24'h0};
    lo_init = 32'h0000_4500 | (b ? 32'h000C_0000 : 32'h0);
    lo_su   = 32'h0000_4600 | (b ? 32'h000C_0000 : 32'h0) | {24'h0, a[19:12]};
    chk(n_wr == 6, "R5", "write count", n_wr, 6);
    chk(err_cnt == 0, "R2", "no error on good address", err_cnt, 0);
    if (n_wr == 6) begin
      for (int m = 0; m < 3; m++) begin
        chk(wr_sel[2*m] == 1'b0 && wr_sel[2*m+1] == 1'b1, "R3", "select order",
            {wr_sel[2*m], wr_sel[2*m+1]}, 2'b01);
        chk(wr_cyc[2*m+1] - wr_cyc[2*m] == 1, "R3", "dest-to-cmd gap",
            wr_cyc[2*m+1] - wr_cyc[2*m], 1);
        chk(wr_dat[2*m] == dexp, b ? "R9" : "R3", "destination word", wr_dat[2*m], dexp);
        chk(wr_dat[2*m+1] == (m == 0 ? lo_init : lo_su), "R4", "command word",
            wr_dat[2*m+1], m == 0 ? lo_init : lo_su);
      end
      chk(wr_dat[3] == wr_dat[5], "R5", "start-up words identical", wr_dat[5], wr_dat[3]);
      // R6 R7: gap = acceptance latency + delay + 1
      chk(wr_cyc[2] - wr_cyc[1] == lat + SHORT_CYC + 1, "R7", "short wait gap",
          wr_cyc[2] - wr_cyc[1], lat + SHORT_CYC + 1);
      chk(wr_cyc[4] - wr_cyc[3] == lat + LONG_CYC + 1, "R7", "long wait gap",
          wr_cyc[4] - wr_cyc[3], lat + LONG_CYC + 1);
      chk(done_cyc - wr_cyc[5] == lat + 1, "R6", "done after final acceptance",
          done_cyc - wr_cyc[5], lat + 1);
    end
    chk(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
    chk(busy_at_done == 1'b0, "R8", "busy low with done", busy_at_done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !error && !cmd_wr, "R1", "outputs after reset",
        {busy, done, error, cmd_wr}, 0);
  endtask

  task automatic t_unicast();
    clear_log(); ack_lat = 1;
    pulse_start(1'b0, 8'h3A, 32'h0009_F000);
    wait_done();
    check_seq(1'b0, 8'h3A, 32'h0009_F000, 1);
  endtask

  task automatic t_slow_ack_top_addr();
    clear_log(); ack_lat = 7;
    pulse_start(1'b0, 8'hC5, 32'h000F_F000);
    wait_done();
    check_seq(1'b0, 8'hC5, 32'h000F_F000, 7);
  endtask

  task automatic t_broadcast();
    clear_log(); ack_lat = 3;
    pulse_start(1'b1, 8'h77, 32'h0000_1000);
    wait_done();
    check_seq(1'b1, 8'h77, 32'h0000_1000, 3);
  endtask

  task automatic t_bad_addr(input logic [31:0] a);
    clear_log();
    pulse_start(1'b0, 8'h12, a);
    repeat (5) @(negedge clk);
    chk(err_cnt == 1, "R2", "one-cycle error", err_cnt, 1);
    chk(n_wr == 0, "R2", "no writes on rejection", n_wr, 0);
    chk(busy_cnt == 0, "R2", "never busy on rejection", busy_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    clear_log(); ack_lat = 4;
    pulse_start(1'b0, 8'h21, 32'h0005_0000);
    for (int i = 0; i < 50 && n_wr < 2; i++) @(negedge clk);
    pulse_start(1'b1, 8'h99, 32'h0000_0123); // R10: must be dropped
    pulse_start(1'b0, 8'h44, 32'h0002_0000);
    wait_done();
    chk(err_cnt == 0, "R10", "no error while busy", err_cnt, 0);
    check_seq(1'b0, 8'h21, 32'h0005_0000, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unicast();
    t_bad_addr(32'h0010_0000);
    t_bad_addr(32'h000F_F800);
    t_slow_ack_top_addr();
    t_broadcast();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule